// File: doc/BRIEF.md
# Quad SPI Transmit Opcode Snooper

This block sits between the transmit FIFO of a SPI flash host controller and the serial shifter that drives the flash buses. While a chip select is active it reads the outgoing byte stream and treats the first byte as a flash opcode. From that opcode it works out how many address bytes follow, how many dummy bytes come after them, and at which byte the data lanes widen from one wire to two or four. It then hands the shifter each byte together with the lane width and the number of shift clocks that byte needs.

Each byte taken from the transmit FIFO is either copied to every flash bus (mirrored) or, in the data phase with striping enabled, split so that each bus gets its own byte. A dummy byte is turned into 8/width idle clocks and its returned data is dropped. Returned bytes are pushed into the receive FIFO unless a discard counter is still running. A full receive FIFO raises a sticky overflow flag, and a shifter that is waiting on an empty FIFO raises a sticky underflow flag. A registered clear input clears both flags.

Top module: `qspi_tx_snooper`

## Requirements
- R1: After reset the lane width output is 1, the cycles-per-byte output is 8, both sticky flags are low, no byte is issued, and the next byte sent under chip select is decoded as an opcode.
- R2: In any cycle with no chip-select bit set, the snooper goes back to opcode decoding, clears its address, dummy and pending-widening counts, and sets the lane width to 1 at the next edge.
- R3: Opcodes 0x03 (read), 0x02 (page program), 0xA2 (dual program) and 0x32 (quad program) are followed by ADDR_BYTES address bytes and no dummy byte.
- R4: Opcodes 0x0B (fast read), 0x3B (dual output read), 0x6B (quad output read) and 0xBB (dual I/O read) are followed by ADDR_BYTES address bytes and one dummy byte. Opcode 0xEB (quad I/O read) is followed by ADDR_BYTES address bytes and two dummy bytes.
- R5: Any other opcode starts a pass-through phase that lasts until chip select drops. In that phase no byte is flagged dummy and the lane width stays 1.
- R6: Opcodes 0x3B and 0xA2 set the lane width to 2, and opcodes 0x6B and 0x32 set it to 4. The change takes effect only for the first byte after the last address or dummy byte.
- R7: Opcode 0xBB sets the lane width to 2 and opcode 0xEB sets it to 4, starting with the first address byte.
- R8: The cycles-per-byte output is 8 divided by the lane width (8, 4, 2), and the dummy output is high for dummy bytes. No receive push and no discard decrement comes from a dummy byte.
- R9: In the pass-through phase with striping enabled, NBUS bytes are popped and bus b carries FIFO byte b. The returned bytes are pushed NBUS at a time, bus 0 in the low byte. Otherwise one byte is popped and copied to every bus, and only bus 0's returned byte is pushed, with the upper push bytes zero.
- R10: A returned byte that finds the receive FIFO full is not pushed, and it sets the overflow flag, which stays set.
- R11: When chip select is active and the shifter is ready but the FIFO holds too few bytes, the underflow flag is set, unless linear mode is selected.
- R12: Any change of the chip-select vector loads the discard counter from the discard input. While the counter is non-zero, each returned non-dummy byte lowers it by 8/width (saturating at zero) and is not pushed.
- R13: The clear input is registered. A clear pulse in cycle t clears both sticky flags at the edge that ends cycle t+1, unless a flag is being set at that same edge.
- R14: A byte is issued, with pop and valid in the same cycle, only when chip select is active, the shifter is ready, and the FIFO count covers the bytes the byte needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_sel_i | input | NUM_CS | Chip-select bits, high = selected |
| stripe_en_i | input | 1 | Enable striping in the pass-through phase |
| linear_mode_i | input | 1 | Memory-mapped mode, suppresses underflow |
| discard_init_i | input | DISC_W | Value loaded into the discard counter on a chip-select change |
| flag_clr_i | input | 1 | Clear request for the sticky flags |
| txf_count_i | input | CNT_W | Bytes held in the transmit FIFO |
| txf_data_i | input | 8*NBUS | FIFO head bytes, byte 0 oldest |
| txf_pop_o | output | 1 | Pop request |
| txf_pop_num_o | output | CNT_W | Bytes to pop |
| shf_ready_i | input | 1 | Shifter can accept a byte |
| shf_valid_o | output | 1 | Byte issued to the shifter |
| shf_data_o | output | 8*NBUS | Per-bus transmit byte |
| shf_lanes_o | output | 3 | Lane width 1, 2 or 4 |
| shf_cycles_o | output | 4 | Shift clocks for this byte |
| shf_dummy_o | output | 1 | Byte is a dummy byte |
| shf_rx_valid_i | input | 1 | Shifter returns received bytes |
| shf_rx_data_i | input | 8*NBUS | Per-bus received bytes |
| rxf_full_i | input | 1 | Receive FIFO cannot accept a push |
| rxf_push_o | output | 1 | Push request |
| rxf_push_num_o | output | CNT_W | Bytes pushed |
| rxf_data_o | output | 8*NBUS | Pushed bytes, byte 0 first |
| underflow_o | output | 1 | Sticky underflow flag |
| overflow_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume the shifter keeps at most one byte in flight. It drops ready after it accepts a byte and pulses its return valid once, and only after that acceptance. They also assume the FIFO count describes the head bytes on the data input. The bench keeps to this by driving each transfer as a fixed three-step exchange: ready with data, then return with ready low, then idle. It changes chip select, the mode inputs and the FIFO count only between exchanges.

// File: rtl/qsnp_pkg.sv
package qsnp_pkg;

   typedef enum logic [1:0] {
      SN_CHECK = 2'd0,
      SN_ADDR  = 2'd1,
      SN_DUMMY = 2'd2,
      SN_PASS  = 2'd3
   } snoop_e;

   typedef struct packed {
      logic       known;
      logic [1:0] dummies;
      logic [2:0] now_lanes;    // 0 = keep current width
      logic [2:0] later_lanes;  // 0 = no deferred widening
   } op_info_t;

   localparam logic [7:0] OP_RD    = 8'h03;
   localparam logic [7:0] OP_PROG  = 8'h02;
   localparam logic [7:0] OP_PROG2 = 8'hA2;
   localparam logic [7:0] OP_PROG4 = 8'h32;
   localparam logic [7:0] OP_FRD   = 8'h0B;
   localparam logic [7:0] OP_ORD2  = 8'h3B;
   localparam logic [7:0] OP_ORD4  = 8'h6B;
   localparam logic [7:0] OP_IORD2 = 8'hBB;
   localparam logic [7:0] OP_IORD4 = 8'hEB;

   function automatic op_info_t decode_op(input logic [7:0] op);
      op_info_t r;
      r = '{known: 1'b1, dummies: 2'd0, now_lanes: 3'd0, later_lanes: 3'd0};
      case (op)
         OP_RD, OP_PROG: ;
         OP_PROG2: r.later_lanes = 3'd2;
         OP_PROG4: r.later_lanes = 3'd4;
         OP_FRD:   r.dummies = 2'd1;
         OP_ORD2:  begin r.dummies = 2'd1; r.later_lanes = 3'd2; end
         OP_ORD4:  begin r.dummies = 2'd1; r.later_lanes = 3'd4; end
         OP_IORD2: begin r.dummies = 2'd1; r.now_lanes = 3'd2; end
         OP_IORD4: begin r.dummies = 2'd2; r.now_lanes = 3'd4; end
         default:  r.known = 1'b0;
      endcase
      return r;
   endfunction

   function automatic logic [3:0] cyc_per_byte(input logic [2:0] lanes);
      case (lanes)
         3'd4:    return 4'd2;
         3'd2:    return 4'd4;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/qsnp_cmd_tracker.sv
module qsnp_cmd_tracker
   import qsnp_pkg::*;
#(
   parameter int ADDR_BYTES = 3
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       cs_any_i,
   input  logic       adv_i,
   input  logic [7:0] op_byte_i,
   output snoop_e     state_o,
   output logic [2:0] lanes_o
);
   localparam int AW = $clog2(ADDR_BYTES + 1);
   localparam int WW = $clog2(ADDR_BYTES + 3);

   snoop_e          state_q;
   logic [AW-1:0]   addr_left_q;
   logic [1:0]      dum_left_q;
   logic [2:0]      lanes_q, lanes_nx_q;
   logic [WW-1:0]   when_q;
   op_info_t        info;

   assign info = decode_op(op_byte_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= SN_CHECK;
         addr_left_q <= '0;
         dum_left_q  <= '0;
         lanes_q     <= 3'd1;
         lanes_nx_q  <= 3'd1;
         when_q      <= '0;
      end else if (!cs_any_i) begin
         state_q     <= SN_CHECK;
         addr_left_q <= '0;
         dum_left_q  <= '0;
         lanes_q     <= 3'd1;
         lanes_nx_q  <= 3'd1;
         when_q      <= '0;
      end else if (adv_i) begin
         if (when_q != '0) begin
            when_q <= when_q - 1'b1;
            if (when_q == WW'(1)) lanes_q <= lanes_nx_q;
         end
         case (state_q)
            SN_CHECK: begin
               if (info.known) begin
                  state_q     <= SN_ADDR;
                  addr_left_q <= AW'(ADDR_BYTES);
                  dum_left_q  <= info.dummies;
                  if (info.now_lanes != 3'd0) lanes_q <= info.now_lanes;
                  if (info.later_lanes != 3'd0) begin
                     lanes_nx_q <= info.later_lanes;
                     when_q     <= WW'(ADDR_BYTES) + WW'(info.dummies);
                  end
               end else begin
                  state_q <= SN_PASS;
               end
            end
            SN_ADDR: begin
               addr_left_q <= addr_left_q - 1'b1;
               if (addr_left_q == AW'(1))
                  state_q <= (dum_left_q != 2'd0) ? SN_DUMMY : SN_PASS;
            end
            SN_DUMMY: begin
               dum_left_q <= dum_left_q - 1'b1;
               if (dum_left_q == 2'd1) state_q <= SN_PASS;
            end
            default: ;
         endcase
      end
   end

   assign state_o = state_q;
   assign lanes_o = lanes_q;

endmodule

// File: rtl/qsnp_tx_fanout.sv
module qsnp_tx_fanout #(
   parameter int NBUS  = 2,
   parameter int CNT_W = 4
) (
   input  logic [CNT_W-1:0]  count_i,
   input  logic [8*NBUS-1:0] head_i,
   input  logic              stripe_i,
   output logic [8*NBUS-1:0] bus_data_o,
   output logic [CNT_W-1:0]  need_o,
   output logic              have_o
);
   localparam logic [CNT_W-1:0] NB = CNT_W'(NBUS);

   for (genvar b = 0; b < NBUS; b++) begin : g_bus
      if (b == 0) begin : g_lead
         assign bus_data_o[7:0] = head_i[7:0];
      end else begin : g_rest
         assign bus_data_o[8*b +: 8] = stripe_i ? head_i[8*b +: 8] : head_i[7:0];
      end
   end

   assign need_o = stripe_i ? NB : CNT_W'(1);
   assign have_o = (count_i >= need_o);

endmodule

// File: rtl/qsnp_rx_sink.sv
module qsnp_rx_sink #(
   parameter int NBUS   = 2,
   parameter int CNT_W  = 4,
   parameter int DISC_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              issue_i,
   input  logic              issue_dummy_i,
   input  logic              issue_stripe_i,
   input  logic [3:0]        issue_cyc_i,
   input  logic              cs_change_i,
   input  logic [DISC_W-1:0] discard_init_i,
   input  logic              rx_valid_i,
   input  logic [8*NBUS-1:0] rx_data_i,
   input  logic              full_i,
   output logic              push_o,
   output logic [CNT_W-1:0]  push_num_o,
   output logic [8*NBUS-1:0] push_data_o,
   output logic              ovf_set_o
);
   logic              pend_dummy_q, pend_stripe_q;
   logic [3:0]        pend_cyc_q;
   logic [DISC_W-1:0] disc_q;
   logic              live;
   logic [DISC_W-1:0] cyc_w;

   assign cyc_w = DISC_W'(pend_cyc_q);
   assign live  = rx_valid_i && !pend_dummy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_dummy_q  <= 1'b0;
         pend_stripe_q <= 1'b0;
         pend_cyc_q    <= 4'd8;
      end else if (issue_i) begin
         pend_dummy_q  <= issue_dummy_i;
         pend_stripe_q <= issue_stripe_i;
         pend_cyc_q    <= issue_cyc_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       disc_q <= '0;
      else if (cs_change_i)              disc_q <= discard_init_i;
      else if (live && disc_q != '0)     disc_q <= (disc_q > cyc_w) ? disc_q - cyc_w : '0;
   end

   assign push_o     = live && (disc_q == '0) && !full_i;
   assign ovf_set_o  = live && (disc_q == '0) && full_i;
   assign push_num_o = pend_stripe_q ? CNT_W'(NBUS) : CNT_W'(1);

   for (genvar b = 0; b < NBUS; b++) begin : g_rx
      if (b == 0) begin : g_lead
         assign push_data_o[7:0] = rx_data_i[7:0];
      end else begin : g_rest
         assign push_data_o[8*b +: 8] = pend_stripe_q ? rx_data_i[8*b +: 8] : 8'h00;
      end
   end

endmodule

// File: rtl/qspi_tx_snooper.sv
module qspi_tx_snooper
   import qsnp_pkg::*;
#(
   parameter int NUM_CS     = 2,
   parameter int NBUS       = 2,
   parameter int CNT_W      = 4,
   parameter int DISC_W     = 8,
   parameter int ADDR_BYTES = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_CS-1:0] cs_sel_i,
   input  logic              stripe_en_i,
   input  logic              linear_mode_i,
   input  logic [DISC_W-1:0] discard_init_i,
   input  logic              flag_clr_i,
   input  logic [CNT_W-1:0]  txf_count_i,
   input  logic [8*NBUS-1:0] txf_data_i,
   output logic              txf_pop_o,
   output logic [CNT_W-1:0]  txf_pop_num_o,
   input  logic              shf_ready_i,
   output logic              shf_valid_o,
   output logic [8*NBUS-1:0] shf_data_o,
   output logic [2:0]        shf_lanes_o,
   output logic [3:0]        shf_cycles_o,
   output logic              shf_dummy_o,
   input  logic              shf_rx_valid_i,
   input  logic [8*NBUS-1:0] shf_rx_data_i,
   input  logic              rxf_full_i,
   output logic              rxf_push_o,
   output logic [CNT_W-1:0]  rxf_push_num_o,
   output logic [8*NBUS-1:0] rxf_data_o,
   output logic              underflow_o,
   output logic              overflow_o
);
   if (NBUS < 1 || NBUS > 4) begin : g_bad_nbus
      $error("NBUS must be 1 to 4");
   end
   if ((1 << CNT_W) <= NBUS) begin : g_bad_cnt
      $error("CNT_W too narrow for NBUS");
   end
   if (DISC_W < 4) begin : g_bad_disc
      $error("DISC_W must be at least 4");
   end
   if (ADDR_BYTES < 1 || ADDR_BYTES > 4) begin : g_bad_addr
      $error("ADDR_BYTES must be 1 to 4");
   end

   snoop_e            state;
   logic [2:0]        lanes;
   logic              cs_any, cs_change, stripe_now, have, issue;
   logic [NUM_CS-1:0] cs_q;
   logic              clr_q, uf_q, of_q, uf_set, of_set;

   assign cs_any    = |cs_sel_i;
   assign cs_change = (cs_sel_i != cs_q);

   if (NBUS > 1) begin : g_stripe
      assign stripe_now = stripe_en_i && (state == SN_PASS);
   end else begin : g_nostripe
      assign stripe_now = 1'b0;
   end

   qsnp_cmd_tracker #(.ADDR_BYTES(ADDR_BYTES)) u_trk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cs_any_i  (cs_any),
      .adv_i     (issue),
      .op_byte_i (txf_data_i[7:0]),
      .state_o   (state),
      .lanes_o   (lanes)
   );

   qsnp_tx_fanout #(.NBUS(NBUS), .CNT_W(CNT_W)) u_tx (
      .count_i    (txf_count_i),
      .head_i     (txf_data_i),
      .stripe_i   (stripe_now),
      .bus_data_o (shf_data_o),
      .need_o     (txf_pop_num_o),
      .have_o     (have)
   );

   assign issue        = cs_any && shf_ready_i && have;
   assign uf_set       = cs_any && shf_ready_i && !have && !linear_mode_i;
   assign shf_valid_o  = issue;
   assign txf_pop_o    = issue;
   assign shf_lanes_o  = lanes;
   assign shf_cycles_o = cyc_per_byte(lanes);
   assign shf_dummy_o  = (state == SN_DUMMY);

   qsnp_rx_sink #(.NBUS(NBUS), .CNT_W(CNT_W), .DISC_W(DISC_W)) u_rx (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .issue_i        (issue),
      .issue_dummy_i  (shf_dummy_o),
      .issue_stripe_i (stripe_now),
      .issue_cyc_i    (shf_cycles_o),
      .cs_change_i    (cs_change),
      .discard_init_i (discard_init_i),
      .rx_valid_i     (shf_rx_valid_i),
      .rx_data_i      (shf_rx_data_i),
      .full_i         (rxf_full_i),
      .push_o         (rxf_push_o),
      .push_num_o     (rxf_push_num_o),
      .push_data_o    (rxf_data_o),
      .ovf_set_o      (of_set)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cs_q  <= '0;
         clr_q <= 1'b0;
         uf_q  <= 1'b0;
         of_q  <= 1'b0;
      end else begin
         cs_q  <= cs_sel_i;
         clr_q <= flag_clr_i;
         uf_q  <= uf_set ? 1'b1 : (clr_q ? 1'b0 : uf_q);
         of_q  <= of_set ? 1'b1 : (clr_q ? 1'b0 : of_q);
      end
   end

   assign underflow_o = uf_q;
   assign overflow_o  = of_q;

endmodule

// File: rtl/qsnp_snoop_chk.sv
module qsnp_snoop_chk #(
   parameter int NUM_CS = 2,
   parameter int CNT_W  = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [NUM_CS-1:0] cs_sel_i,
   input logic              linear_mode_i,
   input logic              flag_clr_i,
   input logic [CNT_W-1:0]  txf_count_i,
   input logic [CNT_W-1:0]  txf_pop_num_o,
   input logic              shf_ready_i,
   input logic              shf_valid_o,
   input logic [2:0]        shf_lanes_o,
   input logic [3:0]        shf_cycles_o,
   input logic              shf_dummy_o,
   input logic              rxf_full_i,
   input logic              rxf_push_o,
   input logic              underflow_o,
   input logic              overflow_o
);
   // R2
   lane_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|cs_sel_i) |=> (shf_lanes_o == 3'd1) && !shf_dummy_o);

   // R14
   issue_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shf_valid_o |-> shf_ready_i && (|cs_sel_i) && (txf_count_i >= txf_pop_num_o));

   // R10
   no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rxf_push_o |-> !rxf_full_i);

   // R8
   dummy_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shf_valid_o && shf_dummy_o) |-> (txf_pop_num_o == CNT_W'(1)));

   // R8
   cycle_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(shf_cycles_o) * int'(shf_lanes_o)) == 8);

   // R11
   uf_linear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(underflow_o) |-> !$past(linear_mode_i));

   // R13
   ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(overflow_o) |-> $past(flag_clr_i, 2));

endmodule

bind qspi_tx_snooper qsnp_snoop_chk #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .cs_sel_i      (cs_sel_i),
   .linear_mode_i (linear_mode_i),
   .flag_clr_i    (flag_clr_i),
   .txf_count_i   (txf_count_i),
   .txf_pop_num_o (txf_pop_num_o),
   .shf_ready_i   (shf_ready_i),
   .shf_valid_o   (shf_valid_o),
   .shf_lanes_o   (shf_lanes_o),
   .shf_cycles_o  (shf_cycles_o),
   .shf_dummy_o   (shf_dummy_o),
   .rxf_full_i    (rxf_full_i),
   .rxf_push_o    (rxf_push_o),
   .underflow_o   (underflow_o),
   .overflow_o    (overflow_o)
);

// File: tb/qspi_tx_snooper_test.sv
`timescale 1ns/1ps
module qspi_tx_snooper_test;
   localparam int NUM_CS = 2, NBUS = 2, CNT_W = 4, DISC_W = 8;

   logic              clk_i = 1'b0, rst_ni = 1'b0;
   logic [NUM_CS-1:0] cs_sel_i = '0;
   logic              stripe_en_i = 1'b0, linear_mode_i = 1'b0, flag_clr_i = 1'b0;
   logic [DISC_W-1:0] discard_init_i = '0;
   logic [CNT_W-1:0]  txf_count_i = '0;
   logic [15:0]       txf_data_i = '0;
   logic              txf_pop_o;
   logic [CNT_W-1:0]  txf_pop_num_o;
   logic              shf_ready_i = 1'b0, shf_valid_o, shf_dummy_o;
   logic [15:0]       shf_data_o;
   logic [2:0]        shf_lanes_o;
   logic [3:0]        shf_cycles_o;
   logic              shf_rx_valid_i = 1'b0;
   logic [15:0]       shf_rx_data_i = '0;
   logic              rxf_full_i = 1'b0, rxf_push_o;
   logic [CNT_W-1:0]  rxf_push_num_o;
   logic [15:0]       rxf_data_o;
   logic              underflow_o, overflow_o;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk_i = ~clk_i;

   qspi_tx_snooper #(.NUM_CS(NUM_CS), .NBUS(NBUS), .CNT_W(CNT_W), .DISC_W(DISC_W)) uut (
      .clk_i(clk_i), .rst_ni(rst_ni), .cs_sel_i(cs_sel_i), .stripe_en_i(stripe_en_i),
      .linear_mode_i(linear_mode_i), .discard_init_i(discard_init_i), .flag_clr_i(flag_clr_i),
      .txf_count_i(txf_count_i), .txf_data_i(txf_data_i), .txf_pop_o(txf_pop_o),
      .txf_pop_num_o(txf_pop_num_o), .shf_ready_i(shf_ready_i), .shf_valid_o(shf_valid_o),
      .shf_data_o(shf_data_o), .shf_lanes_o(shf_lanes_o), .shf_cycles_o(shf_cycles_o),
      .shf_dummy_o(shf_dummy_o), .shf_rx_valid_i(shf_rx_valid_i), .shf_rx_data_i(shf_rx_data_i),
      .rxf_full_i(rxf_full_i), .rxf_push_o(rxf_push_o), .rxf_push_num_o(rxf_push_num_o),
      .rxf_data_o(rxf_data_o), .underflow_o(underflow_o), .overflow_o(overflow_o)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // one exchange: issue with ready, then return data with ready low, then idle
   task automatic xfer(input logic [15:0] tx, input logic [3:0] cnt, input logic [2:0] el,
                       input bit edum, input logic [3:0] epop, input logic [15:0] edata,
                       input bit epush, input logic [3:0] epn, input logic [15:0] erx,
                       input string rq);
      logic [3:0] ecyc;
      ecyc = 4'(8 / int'(el));
      @(negedge clk_i);
      txf_data_i = tx; txf_count_i = cnt; shf_ready_i = 1'b1;
      #0.5;
      chk(shf_valid_o && txf_pop_o, {rq, " valid"}, int'(shf_valid_o), 1);
      chk(shf_lanes_o == el, {rq, " lanes"}, int'(shf_lanes_o), int'(el));
      chk(shf_cycles_o == ecyc, {rq, " cycles"}, int'(shf_cycles_o), int'(ecyc));
      chk(shf_dummy_o == edum, {rq, " dummy"}, int'(shf_dummy_o), int'(edum));
      chk(txf_pop_num_o == epop, {rq, " popnum"}, int'(txf_pop_num_o), int'(epop));
      chk(shf_data_o == edata, {rq, " busdata"}, int'(shf_data_o), int'(edata));
      @(negedge clk_i);
      shf_ready_i = 1'b0; txf_count_i = '0;
      shf_rx_valid_i = 1'b1; shf_rx_data_i = ~tx;
      #0.5;
      chk(rxf_push_o == epush, {rq, " push"}, int'(rxf_push_o), int'(epush));
      if (epush) begin
         chk(rxf_push_num_o == epn, {rq, " pushnum"}, int'(rxf_push_num_o), int'(epn));
         chk(rxf_data_o == erx, {rq, " rxdata"}, int'(rxf_data_o), int'(erx));
      end
      @(negedge clk_i);
      shf_rx_valid_i = 1'b0;
   endtask

   task automatic mir(input logic [7:0] b, input logic [2:0] el, input bit edum,
                      input bit epush, input string rq);
      xfer({8'h00, b}, 4'd1, el, edum, 4'd1, {b, b}, epush, 4'd1, {8'h00, ~b}, rq);
   endtask

   task automatic cs_on();
      @(negedge clk_i); cs_sel_i = 2'b01;
   endtask

   task automatic cs_off();
      @(negedge clk_i); cs_sel_i = 2'b00;
      @(negedge clk_i);
      chk(shf_lanes_o == 3'd1, "R2 lanes after deselect", int'(shf_lanes_o), 1);
   endtask

   task automatic t_reset();
      @(negedge clk_i);
      chk(shf_lanes_o == 3'd1 && shf_cycles_o == 4'd8, "R1 reset width", int'(shf_lanes_o), 1);
      chk(!underflow_o && !overflow_o, "R1 reset flags", int'({underflow_o, overflow_o}), 0);
      chk(!shf_valid_o, "R1 no issue", int'(shf_valid_o), 0);
   endtask

   task automatic t_read();
      cs_on();
      mir(8'h03, 3'd1, 1'b0, 1'b1, "R3 read opcode");
      for (int i = 0; i < 3; i++) mir(8'h10 + 8'(i), 3'd1, 1'b0, 1'b1, "R3 read addr");
      mir(8'h77, 3'd1, 1'b0, 1'b1, "R3 read data not dummy");
      cs_off();
   endtask

   task automatic t_fast();
      cs_on();
      mir(8'h0B, 3'd1, 1'b0, 1'b1, "R4 fast opcode");
      for (int i = 0; i < 3; i++) mir(8'h20 + 8'(i), 3'd1, 1'b0, 1'b1, "R4 fast addr");
      mir(8'hA5, 3'd1, 1'b1, 1'b0, "R8 fast dummy");
      mir(8'h5C, 3'd1, 1'b0, 1'b1, "R9 fast data mirrored");
      cs_off();
   endtask

   task automatic t_dor();
      cs_on();
      mir(8'h3B, 3'd1, 1'b0, 1'b1, "R6 dual out opcode");
      for (int i = 0; i < 3; i++) mir(8'h30 + 8'(i), 3'd1, 1'b0, 1'b1, "R6 dual out addr narrow");
      mir(8'h00, 3'd1, 1'b1, 1'b0, "R6 dual out dummy narrow");
      mir(8'h61, 3'd2, 1'b0, 1'b1, "R6 dual out data wide");
      mir(8'h62, 3'd2, 1'b0, 1'b1, "R6 dual out data wide");
      cs_off();
   endtask

   task automatic t_qior();
      cs_on();
      mir(8'hEB, 3'd1, 1'b0, 1'b1, "R7 quad io opcode");
      for (int i = 0; i < 3; i++) mir(8'h40 + 8'(i), 3'd4, 1'b0, 1'b1, "R7 quad io addr");
      mir(8'hF0, 3'd4, 1'b1, 1'b0, "R4 quad io dummy 1");
      mir(8'hF1, 3'd4, 1'b1, 1'b0, "R4 quad io dummy 2");
      mir(8'h99, 3'd4, 1'b0, 1'b1, "R8 quad io data");
      cs_off();
   endtask

   task automatic t_dior();
      cs_on();
      mir(8'hBB, 3'd1, 1'b0, 1'b1, "R7 dual io opcode");
      for (int i = 0; i < 3; i++) mir(8'h50 + 8'(i), 3'd2, 1'b0, 1'b1, "R7 dual io addr");
      mir(8'hF2, 3'd2, 1'b1, 1'b0, "R8 dual io dummy");
      mir(8'h9A, 3'd2, 1'b0, 1'b1, "R7 dual io data");
      cs_off();
   endtask

   task automatic t_prog();
      cs_on();
      mir(8'hA2, 3'd1, 1'b0, 1'b1, "R6 dual prog opcode");
      for (int i = 0; i < 3; i++) mir(8'h60 + 8'(i), 3'd1, 1'b0, 1'b1, "R6 dual prog addr");
      mir(8'h11, 3'd2, 1'b0, 1'b1, "R6 dual prog data");
      cs_off();
      cs_on();
      mir(8'h32, 3'd1, 1'b0, 1'b1, "R6 quad prog opcode");
      for (int i = 0; i < 3; i++) mir(8'h70 + 8'(i), 3'd1, 1'b0, 1'b1, "R3 quad prog addr");
      mir(8'h12, 3'd4, 1'b0, 1'b1, "R6 quad prog data");
      cs_off();
   endtask

   task automatic t_unknown();
      cs_on();
      mir(8'h9F, 3'd1, 1'b0, 1'b1, "R5 unknown opcode");
      for (int i = 0; i < 5; i++) mir(8'hEB, 3'd1, 1'b0, 1'b1, "R5 pass through");
      cs_off();
   endtask

   task automatic t_stripe();
      stripe_en_i = 1'b1;
      cs_on();
      mir(8'h9F, 3'd1, 1'b0, 1'b1, "R9 opcode mirrored");
      xfer(16'h2211, 4'd2, 3'd1, 1'b0, 4'd2, 16'h2211, 1'b1, 4'd2, 16'hDDEE, "R9 striped");
      xfer(16'h4433, 4'd3, 3'd1, 1'b0, 4'd2, 16'h4433, 1'b1, 4'd2, 16'hBBCC, "R9 striped");
      linear_mode_i = 1'b1;
      @(negedge clk_i);
      txf_data_i = 16'h0055; txf_count_i = 4'd1; shf_ready_i = 1'b1;
      #0.5;
      chk(!shf_valid_o && !txf_pop_o, "R14 short fifo no issue", int'(shf_valid_o), 0);
      @(negedge clk_i);
      shf_ready_i = 1'b0; txf_count_i = '0;
      chk(!underflow_o, "R11 linear suppresses underflow", int'(underflow_o), 0);
      linear_mode_i = 1'b0;
      stripe_en_i = 1'b0;
      cs_off();
   endtask

   task automatic t_overflow();
      cs_on();
      rxf_full_i = 1'b1;
      mir(8'h9F, 3'd1, 1'b0, 1'b0, "R10 full drops byte");
      rxf_full_i = 1'b0;
      chk(overflow_o, "R10 overflow set", int'(overflow_o), 1);
      mir(8'h01, 3'd1, 1'b0, 1'b1, "R10 push resumes");
      chk(overflow_o, "R10 overflow sticky", int'(overflow_o), 1);
      @(negedge clk_i); flag_clr_i = 1'b1;
      @(negedge clk_i); flag_clr_i = 1'b0;
      chk(overflow_o, "R13 clear is registered", int'(overflow_o), 1);
      @(negedge clk_i);
      chk(!overflow_o, "R13 overflow cleared", int'(overflow_o), 0);
      cs_off();
   endtask

   task automatic t_underflow();
      cs_on();
      @(negedge clk_i);
      txf_count_i = '0; shf_ready_i = 1'b1;
      #0.5;
      chk(!shf_valid_o, "R14 empty no issue", int'(shf_valid_o), 0);
      @(negedge clk_i);
      shf_ready_i = 1'b0;
      chk(underflow_o, "R11 underflow set", int'(underflow_o), 1);
      flag_clr_i = 1'b1;
      @(negedge clk_i); flag_clr_i = 1'b0;
      @(negedge clk_i);
      chk(!underflow_o, "R13 underflow cleared", int'(underflow_o), 0);
      cs_off();
   endtask

   task automatic t_discard();
      discard_init_i = 8'd12;
      cs_on();
      mir(8'h03, 3'd1, 1'b0, 1'b0, "R12 discard first");
      mir(8'h00, 3'd1, 1'b0, 1'b0, "R12 discard saturates");
      mir(8'h01, 3'd1, 1'b0, 1'b1, "R12 push after discard");
      discard_init_i = '0;
      cs_off();
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      t_reset();
      t_read();
      t_fast();
      t_dor();
      t_qior();
      t_dior();
      t_prog();
      t_unknown();
      t_stripe();
      t_overflow();
      t_underflow();
      t_discard();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule